// File: doc/BRIEF.md
# Request-Reply Ordering Scoreboard

This block is a synthesizable end-to-end checker that sits beside a unit under observation. It watches that unit's request side and reply side and flags any broken correspondence between the two. Requests carry a small numeric client number. Replies carry a one-hot destination mask. The scoreboard converts the mask to a client number so that both sides share one identity. It then checks that each accepted request is retired exactly once, either by a reply or by an explicit drop indication.

A mode input chooses how strict the ordering check is. In global mode, all identities must retire in the exact order in which their requests were accepted, and the reply and drop paths share that order. In per-identity mode, each client forms its own stream, and different clients may overtake one another. A drain strobe asks whether anything is still outstanding. Every error is reported on a sticky flag that stays set until reset.

Top module: `reqrep_scoreboard`

## Requirements
- R1: An event on either side counts only in a cycle where its valid input is 1 and its busy input is 0. A request or reply offered while busy is 1 is ignored.
- R2: A counted reply whose destination mask does not have exactly one bit set raises err_onehot. That reply retires nothing, so a request it was meant to answer stays outstanding.
- R3: With mode_ooo = 0, a reply's identity is the index of its set mask bit (bit 0 is client 0). It must equal the identity at the head of a single queue of accepted requests. On a mismatch, err_order is raised and the head entry is retired anyway.
- R4: With mode_ooo = 1, a reply or drop is accepted when any request of the same identity is outstanding, whatever the other identities are doing. err_order is never raised in this mode.
- R5: A reply or drop that finds no outstanding request of its identity raises err_unmatched. In global mode this means the queue is empty. A retirement is judged against the state before any request accepted in the same cycle.
- R6: A drop (drop_valid = 1 with drop_id) retires a request exactly as a reply does. When a reply and a drop occur in the same cycle, the reply is applied first and the drop is matched to the following entry.
- R7: Up to 8 requests may be outstanding: 8 in total in global mode, or 8 per identity in per-identity mode. This is counted after same-cycle retirements. A request beyond that limit raises err_overflow and is discarded.
- R8: A drain pulse while any request is outstanding raises err_leftover. A drain pulse with nothing outstanding has no effect.
- R9: All error flags are 0 after reset. Each flag rises on the clock edge that samples its event and then holds until the next reset.
- R10: mode_ooo selects the checking scheme (0 = global order, 1 = per-identity order). It is changed only while nothing is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_ooo | input | 1 | 0 = global order, 1 = per-identity order |
| req_valid | input | 1 | Request valid from the observed unit's input side |
| req_busy | input | 1 | Request busy (back-pressure) on that side |
| req_id | input | 2 | Client number carried by the request |
| rep_valid | input | 1 | Reply valid on the observed unit's output side |
| rep_busy | input | 1 | Reply busy on that side |
| rep_mask | input | 4 | One-hot destination mask of the reply |
| drop_valid | input | 1 | Monitor strobe: the unit consumed a request without replying |
| drop_id | input | 2 | Client number of the dropped request |
| drain | input | 1 | Strobe asking that nothing be outstanding |
| err_unmatched | output | 1 | Sticky: retirement with no matching request |
| err_order | output | 1 | Sticky: global-order violation |
| err_onehot | output | 1 | Sticky: reply mask not one-hot |
| err_overflow | output | 1 | Sticky: request beyond capacity |
| err_leftover | output | 1 | Sticky: drain with requests outstanding |

## Verification
The hardest situations to reach are the ones where several events land in the same cycle. Examples are a reply and a drop retiring two queue entries at once, a request and a reply for an empty queue arriving together, and a ninth request that only overflows because nothing retires in that cycle. Directed sequences drive these coincidences explicitly, after first filling the queue or the per-identity counters with runs of 8 requests. The order in which flags change then identifies which rule was applied. Swapping the reply and drop identities in the dual-retire case shows which of the two was matched against the head.

// File: rtl/sb_pkg.sv
// Shared types for the request-reply scoreboard.
package sb_pkg;

    // Checking scheme selected by the mode input.
    typedef enum logic {
        MODE_GLOBAL = 1'b0,
        MODE_PER_ID = 1'b1
    } sb_mode_e;

    // Per-cycle fault indications raised by a matching engine.
    typedef struct packed {
        logic unmatched;
        logic order;
        logic overflow;
    } sb_fault_t;

endpackage

// File: rtl/sb_norm.sv
// Mask normaliser: turns a destination mask into a client number.
// Assumes: the number is only meaningful when is_onehot is 1.
// For other masks the returned number is the highest set bit (or 0 when none is set).
module sb_norm #(
    parameter int NUM_ID = 4,
    localparam int ID_W  = $clog2(NUM_ID)
) (
    input  logic [NUM_ID-1:0] mask,
    output logic [ID_W-1:0]   id,
    output logic              is_onehot
);

    // Index of the set bit, plus the single-bit check.
    always_comb begin
        id = '0;
        for (int i = 0; i < NUM_ID; i++) begin
            if (mask[i]) id = ID_W'(i);
        end
        is_onehot = ($countones(mask) == 1);
    end

endmodule

// File: rtl/sb_order_fifo.sv
// Global-order engine: one circular queue of outstanding identities.
// Each cycle it accepts up to two retirements (a first, then b) and one push.
// Retirements are judged against the queue state at the start of the cycle,
// before the push. Assumes DEPTH is a power of two.
module sb_order_fifo
    import sb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ID_W   = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             push,
    input  logic [ID_W-1:0]  push_id,
    input  logic             ret_a,
    input  logic [ID_W-1:0]  ret_a_id,
    input  logic             ret_b,
    input  logic [ID_W-1:0]  ret_b_id,
    output logic [CNT_W-1:0] count,
    output sb_fault_t        fault
);

    logic [ID_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [1:0]       n_pop;
    logic [ID_W-1:0]  head0, head1;
    logic [CNT_W-1:0] left;
    logic             do_push;

    // Work out the retirements, the ordering faults and whether the push is accepted.
    always_comb begin
        fault   = '0;
        n_pop   = 2'd0;
        head0   = mem[rd_ptr];
        head1   = mem[PTR_W'(rd_ptr + 1'b1)];
        if (en && ret_a) begin
            if (count == '0) begin
                fault.unmatched = 1'b1;
            end else begin
                n_pop = 2'd1;
                if (head0 != ret_a_id) fault.order = 1'b1;
            end
        end
        if (en && ret_b) begin
            if (count > CNT_W'(n_pop)) begin
                if (((n_pop == 2'd1) ? head1 : head0) != ret_b_id) fault.order = 1'b1;
                n_pop = n_pop + 2'd1;
            end else begin
                fault.unmatched = 1'b1;
            end
        end
        left    = count - CNT_W'(n_pop);
        do_push = en && push && (left != CNT_W'(DEPTH));
        if (en && push && (left == CNT_W'(DEPTH))) fault.overflow = 1'b1;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            rd_ptr <= rd_ptr + PTR_W'(n_pop);
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            count  <= left + CNT_W'(do_push);
        end
    end

    // Storage write (no reset needed: entries are read only while counted).
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_id;
    end

endmodule

// File: rtl/sb_id_counters.sv
// Per-identity engine: one occupancy counter for each client number.
// Order inside an identity is implied, since the entries of one stream are identical.
// Up to two retirements and one push per cycle; retirements are judged before the push.
module sb_id_counters
    import sb_pkg::*;
#(
    parameter int NUM_ID = 4,
    parameter int DEPTH  = 8,
    localparam int ID_W  = $clog2(NUM_ID),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            ret_a,
    input  logic [ID_W-1:0] ret_a_id,
    input  logic            ret_b,
    input  logic [ID_W-1:0] ret_b_id,
    output logic            any_pending,
    output sb_fault_t       fault
);

    logic [NUM_ID-1:0] unm, ovf, nz;

    for (genvar g = 0; g < NUM_ID; g++) begin : g_id
        logic [CNT_W-1:0] cnt, after;
        logic             hit_a, hit_b, take_a, take_b, want, add;

        // Retirements and push that address this identity.
        always_comb begin
            hit_a  = en && ret_a && (ret_a_id == ID_W'(g));
            hit_b  = en && ret_b && (ret_b_id == ID_W'(g));
            take_a = hit_a && (cnt != '0);
            take_b = hit_b && (cnt > CNT_W'(take_a));
            after  = cnt - CNT_W'(take_a) - CNT_W'(take_b);
            want   = en && push && (push_id == ID_W'(g));
            add    = want && (after != CNT_W'(DEPTH));
            unm[g] = (hit_a && !take_a) || (hit_b && !take_b);
            ovf[g] = want && (after == CNT_W'(DEPTH));
            nz[g]  = (cnt != '0);
        end

        // Occupancy register for this identity.
        always_ff @(posedge clk) begin
            if (!rst_n) cnt <= '0;
            else        cnt <= after + CNT_W'(add);
        end
    end

    // Fold the per-identity results together.
    always_comb begin
        fault.unmatched = |unm;
        fault.order     = 1'b0;
        fault.overflow  = |ovf;
        any_pending     = |nz;
    end

endmodule

// File: rtl/reqrep_scoreboard.sv
// Request-reply ordering scoreboard (top).
// Normalises reply masks to client numbers, feeds the engine chosen by mode_ooo
// and keeps sticky error flags. Assumes mode_ooo changes only while idle.
module reqrep_scoreboard
    import sb_pkg::*;
#(
    parameter int NUM_ID = 4,
    parameter int DEPTH  = 8,
    localparam int ID_W  = $clog2(NUM_ID),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ooo,
    input  logic              req_valid,
    input  logic              req_busy,
    input  logic [ID_W-1:0]   req_id,
    input  logic              rep_valid,
    input  logic              rep_busy,
    input  logic [NUM_ID-1:0] rep_mask,
    input  logic              drop_valid,
    input  logic [ID_W-1:0]   drop_id,
    input  logic              drain,
    output logic              err_unmatched,
    output logic              err_order,
    output logic              err_onehot,
    output logic              err_overflow,
    output logic              err_leftover
);

    sb_mode_e         mode;
    logic             req_fire, rep_fire, rep_onehot, rep_take;
    logic [ID_W-1:0]  rep_id;
    logic [CNT_W-1:0] fifo_count;
    logic             ctr_pending, outstanding;
    sb_fault_t        fifo_fault, ctr_fault, fault;

    // Qualify the handshakes on both sides.
    always_comb begin
        mode     = sb_mode_e'(mode_ooo);
        req_fire = req_valid && !req_busy;
        rep_fire = rep_valid && !rep_busy;
        rep_take = rep_fire && rep_onehot;
    end

    sb_norm #(.NUM_ID(NUM_ID)) u_norm (
        .mask      (rep_mask),
        .id        (rep_id),
        .is_onehot (rep_onehot)
    );

    sb_order_fifo #(.DEPTH(DEPTH), .ID_W(ID_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mode == MODE_GLOBAL),
        .push     (req_fire),
        .push_id  (req_id),
        .ret_a    (rep_take),
        .ret_a_id (rep_id),
        .ret_b    (drop_valid),
        .ret_b_id (drop_id),
        .count    (fifo_count),
        .fault    (fifo_fault)
    );

    sb_id_counters #(.NUM_ID(NUM_ID), .DEPTH(DEPTH)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (mode == MODE_PER_ID),
        .push        (req_fire),
        .push_id     (req_id),
        .ret_a       (rep_take),
        .ret_a_id    (rep_id),
        .ret_b       (drop_valid),
        .ret_b_id    (drop_id),
        .any_pending (ctr_pending),
        .fault       (ctr_fault)
    );

    // Select the active engine's view.
    always_comb begin
        fault       = (mode == MODE_PER_ID) ? ctr_fault : fifo_fault;
        outstanding = (mode == MODE_PER_ID) ? ctr_pending : (fifo_count != '0);
    end

    // Sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_unmatched <= 1'b0;
            err_order     <= 1'b0;
            err_onehot    <= 1'b0;
            err_overflow  <= 1'b0;
            err_leftover  <= 1'b0;
        end else begin
            err_unmatched <= err_unmatched | fault.unmatched;
            err_order     <= err_order     | fault.order;
            err_onehot    <= err_onehot    | (rep_fire && !rep_onehot);
            err_overflow  <= err_overflow  | fault.overflow;
            err_leftover  <= err_leftover  | (drain && outstanding);
        end
    end

endmodule

// File: rtl/sb_checker.sv
// Property checker for reqrep_scoreboard, attached by bind.
// Assumes it observes the top's ports and its internal outstanding signal.
module sb_checker #(
    parameter int NUM_ID = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_ooo,
    input logic              rep_valid,
    input logic              rep_busy,
    input logic [NUM_ID-1:0] rep_mask,
    input logic              drop_valid,
    input logic              drain,
    input logic              outstanding,
    input logic              err_unmatched,
    input logic              err_order,
    input logic              err_onehot,
    input logic              err_overflow,
    input logic              err_leftover
);

    logic [4:0] flags;
    assign flags = {err_leftover, err_overflow, err_onehot, err_order, err_unmatched};

    // R2
    onehot_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && !rep_busy && ($countones(rep_mask) != 1)) |=> err_onehot);

    // R9
    sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags)) == $past(flags)));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags == 5'b0));

    // R8
    leftover_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && outstanding) |=> err_leftover);

    // R8
    no_false_leftover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(drain && outstanding) && !err_leftover) |=> !err_leftover);

    // R4
    no_order_per_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ooo && !err_order) |=> !err_order);

    // R5
    quiet_unmatched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rep_valid && !rep_busy) && !drop_valid && !err_unmatched) |=> !err_unmatched);

endmodule

bind reqrep_scoreboard sb_checker #(.NUM_ID(NUM_ID)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_ooo      (mode_ooo),
    .rep_valid     (rep_valid),
    .rep_busy      (rep_busy),
    .rep_mask      (rep_mask),
    .drop_valid    (drop_valid),
    .drain         (drain),
    .outstanding   (outstanding),
    .err_unmatched (err_unmatched),
    .err_order     (err_order),
    .err_onehot    (err_onehot),
    .err_overflow  (err_overflow),
    .err_leftover  (err_leftover)
);

// File: tb/sim_reqrep_scoreboard.sv
module sim_reqrep_scoreboard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_ooo = 1'b0;
    logic       req_valid = 1'b0, req_busy = 1'b0;
    logic [1:0] req_id = '0;
    logic       rep_valid = 1'b0, rep_busy = 1'b0;
    logic [3:0] rep_mask = '0;
    logic       drop_valid = 1'b0;
    logic [1:0] drop_id = '0;
    logic       drain = 1'b0;
    logic       err_unmatched, err_order, err_onehot, err_overflow, err_leftover;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    reqrep_scoreboard u0 (
        .clk(clk), .rst_n(rst_n), .mode_ooo(mode_ooo),
        .req_valid(req_valid), .req_busy(req_busy), .req_id(req_id),
        .rep_valid(rep_valid), .rep_busy(rep_busy), .rep_mask(rep_mask),
        .drop_valid(drop_valid), .drop_id(drop_id), .drain(drain),
        .err_unmatched(err_unmatched), .err_order(err_order), .err_onehot(err_onehot),
        .err_overflow(err_overflow), .err_leftover(err_leftover)
    );

    // flag vector {leftover, overflow, onehot, order, unmatched}
    function automatic logic [4:0] flags();
        return {err_leftover, err_overflow, err_onehot, err_order, err_unmatched};
    endfunction

    // Vector layout: [40] mode, [39:37] request count, [36:29] ids (first at low end),
    // [28:26] retire count, [25:6] retires {drop, mask} (first at low end),
    // [5] drain, [4:0] expected flags.
    localparam int NV = 13;
    localparam logic [40:0] VEC [NV] = '{
        {1'b0, 3'd3, 8'b00_10_01_00, 3'd3, {5'b0, 5'b00100, 5'b00010, 5'b00001}, 1'b1, 5'b00000},
        {1'b0, 3'd2, 8'b00_00_01_00, 3'd2, {5'b0, 5'b0, 5'b00001, 5'b00010}, 1'b1, 5'b00010},
        {1'b1, 3'd2, 8'b00_00_01_00, 3'd2, {5'b0, 5'b0, 5'b00001, 5'b00010}, 1'b1, 5'b00000},
        {1'b1, 3'd2, 8'b00_00_10_10, 3'd1, {5'b0, 5'b0, 5'b0, 5'b00100}, 1'b1, 5'b10000},
        {1'b0, 3'd1, 8'b00_00_00_11, 3'd2, {5'b0, 5'b0, 5'b01000, 5'b01000}, 1'b1, 5'b00001},
        {1'b0, 3'd2, 8'b00_00_10_01, 3'd2, {5'b0, 5'b0, 5'b00100, 5'b10010}, 1'b1, 5'b00000},
        {1'b0, 3'd1, 8'b00_00_00_01, 3'd1, {5'b0, 5'b0, 5'b0, 5'b00000}, 1'b1, 5'b10100},
        {1'b1, 3'd1, 8'b00_00_00_00, 3'd1, {5'b0, 5'b0, 5'b0, 5'b00010}, 1'b1, 5'b10001},
        {1'b0, 3'd2, 8'b00_00_11_00, 3'd2, {5'b0, 5'b0, 5'b00001, 5'b11000}, 1'b1, 5'b00010},
        {1'b1, 3'd3, 8'b00_01_11_01, 3'd3, {5'b0, 5'b00010, 5'b00010, 5'b11000}, 1'b1, 5'b00000},
        {1'b0, 3'd1, 8'b00_00_00_10, 3'd1, {5'b0, 5'b0, 5'b0, 5'b00110}, 1'b1, 5'b10100},
        {1'b1, 3'd1, 8'b00_00_00_00, 3'd0, {5'b0, 5'b0, 5'b0, 5'b0}, 1'b0, 5'b00000},
        {1'b0, 3'd2, 8'b00_00_11_11, 3'd3, {5'b0, 5'b11000, 5'b11000, 5'b11000}, 1'b1, 5'b00001}
    };

    task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: flags actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic restart(bit m);
        @(negedge clk);
        rst_n = 1'b0; mode_ooo = m;
        req_valid = 0; req_busy = 0; rep_valid = 0; rep_busy = 0;
        drop_valid = 0; drain = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_req(logic [1:0] id);
        req_valid = 1'b1; req_id = id;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_ret(logic [4:0] r);
        if (r[4]) begin
            drop_valid = 1'b1;
            drop_id = r[3] ? 2'd3 : r[2] ? 2'd2 : r[1] ? 2'd1 : 2'd0;
        end else begin
            rep_valid = 1'b1; rep_mask = r[3:0];
        end
        @(negedge clk);
        rep_valid = 1'b0; drop_valid = 1'b0;
    endtask

    task automatic pulse_drain();
        drain = 1'b1;
        @(negedge clk);
        drain = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fail++; n_tests++;
                $display("FAIL watchdog: actual=timeout expected=finish");
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        // R9: reset state
        restart(1'b0);
        @(negedge clk);
        check("R9 reset state", flags(), 5'b0);

        // Table walk: covers R2 R3 R4 R5 R6 R8 R10
        for (int v = 0; v < NV; v++) begin
            restart(VEC[v][40]);
            for (int k = 0; k < int'(VEC[v][39:37]); k++) send_req(VEC[v][29 + 2*k +: 2]);
            for (int k = 0; k < int'(VEC[v][28:26]); k++) send_ret(VEC[v][6 + 5*k +: 5]);
            if (VEC[v][5]) pulse_drain();
            check($sformatf("vector %0d (R2 R3 R4 R5 R6 R8 R10)", v), flags(), VEC[v][4:0]);
        end

        // R1: request offered while busy is ignored, so the reply is unmatched
        restart(1'b0);
        req_busy = 1'b1; send_req(2'd0); req_busy = 1'b0;
        send_ret(5'b00001);
        check("R1 busy request ignored", flags(), 5'b00001);

        // R1: reply offered while busy is ignored, request stays outstanding
        restart(1'b0);
        send_req(2'd2);
        rep_busy = 1'b1; send_ret(5'b00100); rep_busy = 1'b0;
        check("R1 busy reply no effect", flags(), 5'b00000);
        pulse_drain();
        check("R1 busy reply leaves request", flags(), 5'b10000);

        // R7: global capacity of 8
        restart(1'b0);
        for (int k = 0; k < 8; k++) send_req(2'd1);
        check("R7 global eight fit", flags(), 5'b0);
        send_req(2'd1);
        check("R7 global ninth overflows", flags(), 5'b01000);
        for (int k = 0; k < 8; k++) send_ret(5'b00010);
        pulse_drain();
        check("R7 overflowed request discarded", flags(), 5'b01000);

        // R7: per-identity capacity of 8 each
        restart(1'b1);
        for (int k = 0; k < 8; k++) send_req(2'd0);
        for (int k = 0; k < 8; k++) send_req(2'd1);
        check("R7 per-id sixteen fit", flags(), 5'b0);
        send_req(2'd0);
        check("R7 per-id ninth overflows", flags(), 5'b01000);

        // R7: a full queue accepts a request in the cycle one entry retires
        restart(1'b0);
        for (int k = 0; k < 8; k++) send_req(2'd3);
        req_valid = 1'b1; req_id = 2'd3; rep_valid = 1'b1; rep_mask = 4'b1000;
        @(negedge clk);
        req_valid = 1'b0; rep_valid = 1'b0;
        check("R7 retire frees room same cycle", flags(), 5'b0);

        // R6: reply and drop together, reply matched first
        restart(1'b0);
        send_req(2'd0); send_req(2'd1);
        rep_valid = 1'b1; rep_mask = 4'b0001; drop_valid = 1'b1; drop_id = 2'd1;
        @(negedge clk);
        rep_valid = 1'b0; drop_valid = 1'b0;
        pulse_drain();
        check("R6 dual retire in order", flags(), 5'b0);

        restart(1'b0);
        send_req(2'd0); send_req(2'd1);
        rep_valid = 1'b1; rep_mask = 4'b0010; drop_valid = 1'b1; drop_id = 2'd0;
        @(negedge clk);
        rep_valid = 1'b0; drop_valid = 1'b0;
        check("R6 dual retire reply goes first", flags(), 5'b00010);

        // R5: request and reply in the same cycle on an empty queue
        restart(1'b0);
        req_valid = 1'b1; req_id = 2'd0; rep_valid = 1'b1; rep_mask = 4'b0001;
        @(negedge clk);
        req_valid = 1'b0; rep_valid = 1'b0;
        check("R5 same-cycle reply sees empty", flags(), 5'b00001);
        pulse_drain();
        check("R5 same-cycle request kept", flags(), 5'b10001);

        // R9: flags hold over idle cycles
        repeat (5) @(negedge clk);
        check("R9 flags sticky", flags(), 5'b10001);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule